// File: doc/BRIEF.md
# MII Receive Deframer with Pad Stripping

This block sits behind a media-independent interface PHY and turns the 4-bit receive stream into bytes for a receive FIFO. While the receive data-valid input is high, it drops preamble nibbles and looks for the start-of-frame nibble. It then pairs the nibbles that follow into bytes, low nibble first, and writes each byte to the FIFO write port two clock cycles after its high nibble arrives. A mode input covers PHYs that put the start-of-frame nibble first, with no preamble in front of it.

With pad stripping enabled, the block reads the 16-bit length/type field. If that value is under the minimum data size of 46, only the 14 header bytes and that many data bytes reach the FIFO, so the pad and the frame check sequence are held back. The CRC-32 is still run over every received byte. When data-valid falls, a single end-of-frame pulse carries four results: CRC error, runt (under 64 bytes, so the host can discard collision fragments), alignment error and the full received byte count.

Top module: `mii_rx_deframer`

## Requirements
- R1: With `sfd_first_i` low, nibbles are discarded until the first nibble equal to 4'hD. The frame's first byte is made of the two nibbles after that one.
- R2: With `sfd_first_i` high, the first nibble sampled with `rx_dv_i` high is taken as the start-of-frame nibble, whatever its value. The next nibble starts byte 0.
- R3: Each byte is {second nibble, first nibble}. Bytes go out on `wr_data_o` with `wr_valid_o` in arrival order. Bytes 0 to 13 are always written.
- R4: With `strip_en_i` high, let L be the value of bytes 12 and 13 (byte 12 is the upper 8 bits). If L < 46, only bytes with index below 14+L are written, so the pad and FCS are dropped.
- R5: If L >= 46, which includes type values of 16'h0600 and above, every byte including the FCS is written, whatever the frame length.
- R6: With `strip_en_i` low, every received byte is written.
- R7: `crc_err_o` is 0 only when the CRC-32 residue over all complete bytes, FCS included, equals 32'hC704DD7B (MSB-first form). This also holds when bytes were stripped.
- R8: `runt_o` is 1 when fewer than 64 complete bytes followed the start-of-frame nibble.
- R9: `align_err_o` is 1 when the frame ended on an odd number of nibbles after the start-of-frame nibble. The trailing nibble is not counted as a byte.
- R10: `eof_o` pulses for one cycle, two cycles after the first clock edge at which `rx_dv_i` is sampled low. `byte_cnt_o` then holds the number of complete bytes received. The status outputs hold their values until the next pulse.
- R11: After reset, and while `rx_dv_i` stays low, `wr_valid_o` and `eof_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Receive clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rxd_i | input | 4 | Receive nibble from the PHY |
| rx_dv_i | input | 1 | Receive data valid from the PHY |
| sfd_first_i | input | 1 | Start-of-frame nibble comes first, with no preamble |
| strip_en_i | input | 1 | Enable length-based pad and FCS removal |
| wr_valid_o | output | 1 | FIFO write strobe |
| wr_data_o | output | 8 | FIFO write byte |
| eof_o | output | 1 | End-of-frame status strobe |
| crc_err_o | output | 1 | CRC residue mismatch |
| runt_o | output | 1 | Frame shorter than 64 bytes |
| align_err_o | output | 1 | Odd nibble count |
| byte_cnt_o | output | 16 | Complete bytes received after the start-of-frame nibble |

## Verification
The bench targets the cut-off point of stripping.

- A length of 16 padded to 64 bytes must write exactly 30 bytes. An off-by-one in the cut-off adds or loses one byte against the reference queue.
- A length of exactly 46 must write all 64 bytes. A strict/non-strict comparison mix-up shows up there.
- A length larger than the bytes actually received must write every byte that arrived.
- A corrupted frame with stripping enabled must still raise the CRC flag. A design that stopped the CRC at the cut-off would report it clean.

The bench also covers the start of a frame:

- a noise nibble inside the preamble;
- the mode where the start-of-frame nibble comes first, where a design that hunted for 4'hD would lose the whole frame.

Finally, it checks a trailing odd nibble, which must raise the alignment flag without adding to the byte count.

// File: rtl/mii_rx_pkg.sv
package mii_rx_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_HUNT, ST_BODY} rx_state_e;

  localparam logic [3:0]  SFD_NIB       = 4'hD;
  localparam logic [31:0] CRC_POLY_REFL = 32'hEDB88320;
  localparam logic [31:0] RESIDUE_MSB   = 32'hC704DD7B;

  function automatic logic [31:0] crc_next(logic [31:0] c, logic [7:0] d);
    logic [31:0] r;
    r = c ^ {24'd0, d};
    for (int i = 0; i < 8; i++) r = r[0] ? ((r >> 1) ^ CRC_POLY_REFL) : (r >> 1);
    return r;
  endfunction

  function automatic logic [31:0] rev32(logic [31:0] v);
    logic [31:0] r;
    for (int i = 0; i < 32; i++) r[i] = v[31-i];
    return r;
  endfunction
endpackage

// File: rtl/mii_nibble_align.sv
module mii_nibble_align
  import mii_rx_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [3:0] rxd_i,
  input  logic       rx_dv_i,
  input  logic       sfd_first_i,
  output logic       start_o,
  output logic       byte_vld_o,
  output logic [7:0] byte_o,
  output logic       end_o,
  output logic       odd_o
);
  rx_state_e  state_q;
  logic       half_q;
  logic [3:0] low_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      half_q     <= 1'b0;
      low_q      <= '0;
      start_o    <= 1'b0;
      byte_vld_o <= 1'b0;
      byte_o     <= '0;
      end_o      <= 1'b0;
      odd_o      <= 1'b0;
    end else begin
      start_o    <= 1'b0;
      byte_vld_o <= 1'b0;
      end_o      <= 1'b0;
      if (!rx_dv_i) begin
        if (state_q == ST_BODY) begin
          end_o <= 1'b1;
          odd_o <= half_q;
        end
        state_q <= ST_IDLE;
        half_q  <= 1'b0;
      end else begin
        unique case (state_q)
          ST_IDLE: begin
            // first nibble of the burst: taken as SFD in the no-preamble mode
            if (sfd_first_i || rxd_i == SFD_NIB) begin
              state_q <= ST_BODY;
              start_o <= 1'b1;
            end else begin
              state_q <= ST_HUNT;
            end
          end
          ST_HUNT: begin
            if (rxd_i == SFD_NIB) begin
              state_q <= ST_BODY;
              start_o <= 1'b1;
            end
          end
          ST_BODY: begin
            if (!half_q) begin
              low_q  <= rxd_i;
              half_q <= 1'b1;
            end else begin
              byte_o     <= {rxd_i, low_q};
              byte_vld_o <= 1'b1;
              half_q     <= 1'b0;
            end
          end
          default: state_q <= ST_IDLE;
        endcase
      end
    end
  end

  p_byte_needs_dv_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    byte_vld_o |-> $past(rx_dv_i));
  p_end_after_drop_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    end_o |-> ($past(!rx_dv_i) && !byte_vld_o));
  p_sfd_first_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_IDLE && rx_dv_i && sfd_first_i) |=> start_o);
  p_start_single_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_o |=> !start_o);
endmodule

// File: rtl/mii_crc_check.sv
module mii_crc_check
  import mii_rx_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       start_i,
  input  logic       byte_vld_i,
  input  logic [7:0] byte_i,
  output logic       crc_ok_o
);
  localparam logic [31:0] RESIDUE_REFL = rev32(RESIDUE_MSB);

  logic [31:0] crc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         crc_q <= '1;
    else if (start_i)    crc_q <= '1;
    else if (byte_vld_i) crc_q <= crc_next(crc_q, byte_i);
  end

  assign crc_ok_o = (crc_q == RESIDUE_REFL);

  p_crc_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!start_i && !byte_vld_i) |=> $stable(crc_q));
endmodule

// File: rtl/mii_pad_gate.sv
module mii_pad_gate #(
  parameter int CNT_W     = 16,
  parameter int HDR_BYTES = 14,
  parameter int MIN_DATA  = 46,
  parameter int LEN_OFS   = 12
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             byte_vld_i,
  input  logic [7:0]       byte_i,
  input  logic             strip_en_i,
  output logic             out_valid_o,
  output logic [7:0]       out_data_o,
  output logic [CNT_W-1:0] count_o
);
  localparam logic [CNT_W-1:0] LEN_HI_IDX = CNT_W'(LEN_OFS);
  localparam logic [CNT_W-1:0] LEN_LO_IDX = CNT_W'(LEN_OFS + 1);

  logic [CNT_W-1:0] cnt_q;
  logic [15:0]      len_q;
  logic             past_hdr, short_len, beyond, fwd;

  assign past_hdr  = 32'(cnt_q) >= 32'(HDR_BYTES);
  assign short_len = len_q < 16'(MIN_DATA);
  assign beyond    = 32'(cnt_q) >= (32'(HDR_BYTES) + 32'(len_q));
  assign fwd       = !(strip_en_i && past_hdr && short_len && beyond);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q       <= '0;
      len_q       <= '1;
      out_valid_o <= 1'b0;
      out_data_o  <= '0;
    end else begin
      out_valid_o <= 1'b0;
      if (start_i) begin
        cnt_q <= '0;
        len_q <= '1;
      end else if (byte_vld_i) begin
        if (cnt_q == LEN_HI_IDX) len_q[15:8] <= byte_i;
        if (cnt_q == LEN_LO_IDX) len_q[7:0]  <= byte_i;
        if (cnt_q != '1) cnt_q <= cnt_q + 1'b1;
        out_valid_o <= fwd;
        out_data_o  <= byte_i;
      end
    end
  end

  assign count_o = cnt_q;

  p_hdr_always_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (byte_vld_i && !start_i && !past_hdr) |=> out_valid_o);
  p_nostrip_all_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (byte_vld_i && !start_i && !strip_en_i) |=> out_valid_o);
  p_long_len_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (byte_vld_i && !start_i && past_hdr && len_q >= 16'(MIN_DATA)) |=> out_valid_o);
  p_cnt_step_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (byte_vld_i && !start_i && cnt_q != '1) |=> (cnt_q == $past(cnt_q) + 1'b1));
endmodule

// File: rtl/mii_rx_deframer.sv
module mii_rx_deframer #(
  parameter int CNT_W     = 16,
  parameter int MIN_FRAME = 64,
  parameter int MIN_DATA  = 46,
  parameter int HDR_BYTES = 14,
  parameter int LEN_OFS   = 12
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [3:0]       rxd_i,
  input  logic             rx_dv_i,
  input  logic             sfd_first_i,
  input  logic             strip_en_i,
  output logic             wr_valid_o,
  output logic [7:0]       wr_data_o,
  output logic             eof_o,
  output logic             crc_err_o,
  output logic             runt_o,
  output logic             align_err_o,
  output logic [CNT_W-1:0] byte_cnt_o
);
  logic             start, byte_vld, frame_end, odd, crc_ok;
  logic [7:0]       byte_d;
  logic [CNT_W-1:0] cnt;

  mii_nibble_align u_align (
    .clk_i, .rst_ni, .rxd_i, .rx_dv_i, .sfd_first_i,
    .start_o(start), .byte_vld_o(byte_vld), .byte_o(byte_d),
    .end_o(frame_end), .odd_o(odd)
  );

  mii_crc_check u_crc (
    .clk_i, .rst_ni, .start_i(start), .byte_vld_i(byte_vld),
    .byte_i(byte_d), .crc_ok_o(crc_ok)
  );

  mii_pad_gate #(
    .CNT_W(CNT_W), .HDR_BYTES(HDR_BYTES), .MIN_DATA(MIN_DATA), .LEN_OFS(LEN_OFS)
  ) u_gate (
    .clk_i, .rst_ni, .start_i(start), .byte_vld_i(byte_vld), .byte_i(byte_d),
    .strip_en_i, .out_valid_o(wr_valid_o), .out_data_o(wr_data_o), .count_o(cnt)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      eof_o       <= 1'b0;
      crc_err_o   <= 1'b0;
      runt_o      <= 1'b0;
      align_err_o <= 1'b0;
      byte_cnt_o  <= '0;
    end else begin
      eof_o <= frame_end;
      if (frame_end) begin
        crc_err_o   <= !crc_ok;
        runt_o      <= 32'(cnt) < 32'(MIN_FRAME);
        align_err_o <= odd;
        byte_cnt_o  <= cnt;
      end
    end
  end

  p_eof_single_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eof_o |=> !eof_o);
  p_idle_quiet_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(!rx_dv_i) && $past(!rx_dv_i, 2)) |-> !wr_valid_o);
  p_runt_match_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eof_o |-> (runt_o == (32'(byte_cnt_o) < 32'(MIN_FRAME))));
  p_status_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(frame_end) |-> ($stable(crc_err_o) && $stable(byte_cnt_o)));
endmodule

// File: tb/mii_rx_deframer_test.sv
module mii_rx_deframer_test;
  typedef logic [7:0] bq_t[$];

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [3:0]  rxd = '0;
  logic        rx_dv = 1'b0;
  logic        sfd_first = 1'b0;
  logic        strip_en = 1'b0;
  logic        wr_valid, eof, crc_err, runt, align_err;
  logic [7:0]  wr_data;
  logic [15:0] byte_cnt;

  int    total = 0;
  int    bad = 0;
  int    cycles = 0;
  bq_t   exp_q;
  string cur_tag = "R11";

  always #4 clk = ~clk;

  mii_rx_deframer uut (
    .clk_i(clk), .rst_ni(rst_ni), .rxd_i(rxd), .rx_dv_i(rx_dv),
    .sfd_first_i(sfd_first), .strip_en_i(strip_en),
    .wr_valid_o(wr_valid), .wr_data_o(wr_data), .eof_o(eof),
    .crc_err_o(crc_err), .runt_o(runt), .align_err_o(align_err),
    .byte_cnt_o(byte_cnt)
  );

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] ref_fcs(input bq_t q);
    logic [31:0] c = 32'hFFFF_FFFF;
    foreach (q[i]) begin
      c ^= {24'd0, q[i]};
      for (int k = 0; k < 8; k++) c = c[0] ? ((c >> 1) ^ 32'hEDB88320) : (c >> 1);
    end
    return ~c;
  endfunction

  // header + payload (+ zero pad up to 60) + FCS, optionally corrupted
  function automatic bq_t make_frame(input int len_field, input int pay,
                                     input bit pad60, input bit corrupt);
    bq_t q;
    logic [31:0] f;
    for (int i = 0; i < 12; i++) q.push_back(8'(8'h10 + i));
    q.push_back(len_field[15:8]);
    q.push_back(len_field[7:0]);
    for (int i = 0; i < pay; i++) q.push_back(8'(i * 7 + 3));
    while (pad60 && q.size() < 60) q.push_back(8'h00);
    f = ref_fcs(q);
    for (int i = 0; i < 4; i++) q.push_back(f[8*i +: 8]);
    if (corrupt) q[15] = q[15] ^ 8'h40;
    return q;
  endfunction

  // byte stream compared against the reference queue on every clock
  always @(negedge clk) begin
    if (rst_ni && wr_valid) begin
      if (exp_q.size() == 0) check({cur_tag, " unexpected byte"}, int'(wr_data), -1);
      else check({cur_tag, " byte"}, int'(wr_data), int'(exp_q.pop_front()));
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      bad++; total++;
      $display("FAIL watchdog actual=%0d expected<100000", cycles);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic send(input bq_t fr, input bit sfdf, input int pre, input bit noise,
                      input bit strip, input bit odd, input string tag);
    int n = fr.size();
    int l = 16'hFFFF;
    int fwd = n;
    bit good_crc = 1'b0;
    bq_t body;
    logic [31:0] f;
    if (n >= 14) l = {fr[12], fr[13]};
    if (strip && n >= 14 && l < 46 && 14 + l < n) fwd = 14 + l;
    for (int i = 0; i < fwd; i++) exp_q.push_back(fr[i]);
    if (n >= 4) begin
      for (int i = 0; i < n - 4; i++) body.push_back(fr[i]);
      f = ref_fcs(body);
      good_crc = (f == {fr[n-1], fr[n-2], fr[n-3], fr[n-4]});
    end
    cur_tag = tag;
    sfd_first = sfdf;
    strip_en = strip;
    rx_dv = 1'b1;
    if (sfdf) begin
      rxd = 4'h3;
      @(negedge clk);
    end else begin
      for (int i = 0; i < pre; i++) begin
        rxd = (noise && i == 2) ? 4'h2 : 4'h5;
        @(negedge clk);
      end
      rxd = 4'hD;
      @(negedge clk);
    end
    foreach (fr[i]) begin
      rxd = fr[i][3:0]; @(negedge clk);
      rxd = fr[i][7:4]; @(negedge clk);
    end
    if (odd) begin
      rxd = 4'hA; @(negedge clk);
    end
    rx_dv = 1'b0;
    rxd = '0;
    @(negedge clk);
    check({tag, " R10 eof early"}, int'(eof), 0);
    @(negedge clk);
    check({tag, " R10 eof"}, int'(eof), 1);
    check({tag, " R7 crc_err"}, int'(crc_err), int'(!good_crc));
    check({tag, " R8 runt"}, int'(runt), int'(n < 64));
    check({tag, " R9 align"}, int'(align_err), int'(odd));
    check({tag, " R10 count"}, int'(byte_cnt), n);
    @(negedge clk);
    check({tag, " R10 eof one cycle"}, int'(eof), 0);
    repeat (3) @(negedge clk);
    check({tag, " leftover bytes"}, exp_q.size(), 0);
    exp_q.delete();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R11 reset wr_valid", int'(wr_valid), 0);
    check("R11 reset eof", int'(eof), 0);
    rst_ni = 1'b1;
    repeat (4) @(negedge clk);
    check("R11 idle wr_valid", int'(wr_valid), 0);
    // R4: length 16 padded to 64 bytes, stripped to 30
    send(make_frame(16, 16, 1, 0), 0, 15, 0, 1, 0, "R4");
    // R6: same frame, stripping off
    send(make_frame(16, 16, 1, 0), 0, 15, 0, 0, 0, "R6");
    // R5: length exactly 46
    send(make_frame(46, 46, 1, 0), 0, 15, 0, 1, 0, "R5");
    // R5: type value
    send(make_frame(16'h0800, 50, 1, 0), 0, 7, 0, 1, 0, "R5");
    // R1: noise nibble inside preamble
    send(make_frame(20, 20, 1, 0), 0, 9, 1, 1, 0, "R1");
    // R2: start-of-frame nibble first, value not 4'hD
    send(make_frame(20, 20, 1, 0), 1, 0, 0, 1, 0, "R2");
    // R7: corrupted frame with stripping still flags CRC
    send(make_frame(10, 10, 1, 1), 0, 15, 0, 1, 0, "R7");
    // R8: runt, stripping off
    send(make_frame(12, 12, 0, 0), 0, 15, 0, 0, 0, "R8");
    // R4: length beyond received bytes writes all that arrived
    send(make_frame(40, 10, 0, 0), 0, 15, 0, 1, 0, "R4");
    // R9: trailing odd nibble
    send(make_frame(46, 46, 1, 0), 0, 15, 0, 0, 1, "R9");
    // R3: long frame, stripping off
    send(make_frame(100, 100, 0, 0), 0, 15, 0, 0, 0, "R3");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule